// File: doc/BRIEF.md
# Buck/Boost Voltage-Mode PWM Generator

This block turns an 8-bit error code from an external loop into a single fixed-frequency pulse train for a one-switch converter. A free-running 8-bit ramp sets the switching period at 256 clocks. At the start of each period a pulse width is chosen: the smallest of the width implied by the error code, a programmable duty cap, a soft-start clamp and a hard 98% ceiling. The ramp is compared with that stored width, and the result appears on one of two drive outputs. Which output switches depends on the topology. Buck drives the high-side output, boost drives the low-side output, and the idle side is held low.

The error code has dead zones at both ends of its range. On a scale where code 255 stands for 5 units, codes under 26 (0.5 units) give no pulse. Codes from 230 (4.5 units) upward give the largest allowed pulse. Between these bounds the width grows linearly. A single run condition gates the block: enable high, external status good, no undervoltage flag and no overtemperature flag. Losing that condition stops switching at once and rearms soft start. The topology input is captured only when the block starts.

The sequencer has four states. ST_OFF is stopped, with outputs low and soft start cleared. ST_SYNC waits for the next period boundary. ST_SOFT switches while the clamp opens. ST_RUN switches with the clamp fully open. The transitions are as follows. ST_OFF goes to ST_SYNC when the run condition holds, capturing the topology. ST_SYNC goes to ST_SOFT at the period end. ST_SOFT goes to ST_RUN at a period end with the clamp at full scale. Any state returns to ST_OFF when the run condition is lost.

Top module: `pwm_drive_ctrl`

## Requirements
- R1: An error code below 26 gives zero pulse width, so neither drive output goes high. Code 26 itself also gives width 0.
- R2: For error codes 26 to 229, the width in clocks per 256-clock period is floor((code-26)*256/204). For example, code 77 gives 64, code 128 gives 128 and code 179 gives 192.
- R3: An error code of 230 or more gives the largest allowed width. That is 250 clocks unless the cap is lower.
- R4: No period's pulse exceeds 250 of 256 clocks (98%) for any input. This includes code 229, whose linear value would be 254.
- R5: With cap_use=1, the width is at most duty_cap clocks per period (duty_cap in 1/256 units). Cap 0 gives no pulse.
- R6: With cap_use=0, or with a cap above 250, the limit falls back to 250 clocks.
- R7: With topology buck (mode_sel=1 captured), only drv_hi pulses and drv_lo stays low. With boost (mode_sel=0 captured), only drv_lo pulses and drv_hi stays low.
- R8: mode_sel is captured only when the block leaves the stopped state. Changing it while running has no effect until a stop and restart.
- R9: If run_en is low, ext_ok is low, uv_flag is high or ot_flag is high at a clock edge, both outputs are low from that edge on.
- R10: After every start, the first full period and the partial period before it carry no pulse. The width then opens by 16 clocks per period until the other limits govern. A stop rearms this sequence.
- R11: The width is only taken at a period boundary, so each period has exactly one contiguous pulse even if the error code changes every clock.
- R12: After reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enable, high to run |
| ext_ok | input | 1 | External status, low stops switching |
| uv_flag | input | 1 | Supply undervoltage, high stops switching |
| ot_flag | input | 1 | Overtemperature, high stops switching |
| mode_sel | input | 1 | Topology request: 1 buck, 0 boost |
| err_code | input | 8 | Error code from the external loop |
| duty_cap | input | 8 | Programmed duty limit in 1/256 of a period |
| cap_use | input | 1 | Apply duty_cap when high |
| drv_hi | output | 1 | High-side drive (buck) |
| drv_lo | output | 1 | Low-side drive (boost) |

## Verification
The hardest behaviour to reach from the ports is the runt-free update. A register at a period boundary and a comparator working straight from the error code give the same duty under a steady code, so a steady code cannot tell them apart. The stimulus therefore toggles the error code every clock while the block runs. It counts rising edges of the drive output over exactly four periods and expects four. The soft-start ramp is also awkward, because its phase against the free-running ramp is unknown at restart. The bench checks a guaranteed-dark first window and a bounded partial width a few periods later.

// File: rtl/pwm_drv_pkg.sv
package pwm_drv_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SYNC = 2'd1,
        ST_SOFT = 2'd2,
        ST_RUN  = 2'd3
    } drv_state_t;

    typedef enum logic {
        TOPO_BOOST = 1'b0,
        TOPO_BUCK  = 1'b1
    } topo_t;

    // code nearest to tenths/10 of full scale fs
    function automatic int win_code(input int fs, input int tenths);
        return (fs * tenths + 5) / 10;
    endfunction

endpackage

// File: rtl/pwm_ramp_cnt.sv
module pwm_ramp_cnt #(
    parameter int RAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [RAMP_W-1:0] cnt_o,
    output logic              wrap_o
);

    logic [RAMP_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == {RAMP_W{1'b1}});

endmodule

// File: rtl/pwm_width_calc.sv
module pwm_width_calc #(
    parameter int CODE_W = 8,
    parameter int RAMP_W = 8,
    parameter int WIN_LO = 26,
    parameter int WIN_HI = 230,
    parameter int CEIL   = 250
) (
    input  logic [CODE_W-1:0] comp_i,
    input  logic [CODE_W-1:0] cap_i,
    input  logic              cap_use_i,
    input  logic [RAMP_W:0]   ss_i,
    output logic [RAMP_W:0]   width_o
);

    localparam int WID_W = RAMP_W + 1;
    localparam int PW    = CODE_W + RAMP_W + 1;
    localparam int SPAN  = WIN_HI - WIN_LO;

    localparam logic [CODE_W-1:0] LO_V   = CODE_W'(WIN_LO);
    localparam logic [CODE_W-1:0] HI_V   = CODE_W'(WIN_HI);
    localparam logic [WID_W-1:0]  CEIL_V = WID_W'(CEIL);
    localparam logic [PW-1:0]     SPAN_V = PW'(SPAN);

    logic [CODE_W-1:0] diff;
    logic [PW-1:0]     scaled;
    logic [PW-1:0]     cap_scaled;
    logic [WID_W-1:0]  lin_w;
    logic [WID_W-1:0]  comp_w;
    logic [WID_W-1:0]  cap_w;
    logic [WID_W-1:0]  cap_lim;
    logic [WID_W-1:0]  pick;

    // linear section of the window, scaled to ramp clocks
    always_comb begin
        diff   = comp_i - LO_V;
        scaled = {{(RAMP_W + 1){1'b0}}, diff} << RAMP_W;
        lin_w  = WID_W'(scaled / SPAN_V);
    end

    // dead zones at both ends of the error range
    always_comb begin
        if (comp_i < LO_V) begin
            comp_w = '0;
        end else if (comp_i >= HI_V) begin
            comp_w = CEIL_V;
        end else begin
            comp_w = lin_w;
        end
    end

    // programmed duty limit, falling back to the hard ceiling
    always_comb begin
        cap_scaled = ({{(RAMP_W + 1){1'b0}}, cap_i} << RAMP_W) >> CODE_W;
        cap_w      = WID_W'(cap_scaled);
        if (cap_use_i && (cap_w < CEIL_V)) begin
            cap_lim = cap_w;
        end else begin
            cap_lim = CEIL_V;
        end
    end

    // smallest of all limits
    always_comb begin
        pick = comp_w;
        if (cap_lim < pick) begin
            pick = cap_lim;
        end
        if (ss_i < pick) begin
            pick = ss_i;
        end
        if (CEIL_V < pick) begin
            pick = CEIL_V;
        end
        width_o = pick;
    end

endmodule

// File: rtl/pwm_seq_fsm.sv
module pwm_seq_fsm
    import pwm_drv_pkg::*;
#(
    parameter int RAMP_W  = 8,
    parameter int SS_STEP = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_i,
    input  logic           wrap_i,
    input  logic           mode_i,
    output drv_state_t     state_o,
    output topo_t          topo_o,
    output logic [RAMP_W:0] ss_o
);

    localparam int WID_W = RAMP_W + 1;
    localparam logic [WID_W-1:0] FULL = WID_W'(2 ** RAMP_W);
    localparam logic [WID_W-1:0] STEP = WID_W'(SS_STEP);

    drv_state_t       state_q;
    drv_state_t       state_d;
    topo_t            topo_q;
    logic [WID_W-1:0] ss_q;
    logic [WID_W-1:0] ss_inc;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!go_i) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_SYNC;
                ST_SYNC: if (wrap_i) state_d = ST_SOFT;
                ST_SOFT: if (wrap_i && (ss_q == FULL)) state_d = ST_RUN;
                ST_RUN:  state_d = ST_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // saturating soft-start step
    always_comb begin
        if (ss_q >= (FULL - STEP)) begin
            ss_inc = FULL;
        end else begin
            ss_inc = ss_q + STEP;
        end
    end

    // topology capture and soft-start clamp
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            topo_q <= TOPO_BUCK;
            ss_q   <= '0;
        end else if (state_q == ST_OFF) begin
            ss_q <= '0;
            if (go_i) begin
                topo_q <= topo_t'(mode_i);
            end
        end else if (wrap_i) begin
            ss_q <= ss_inc;
        end
    end

    assign state_o = state_q;
    assign topo_o  = topo_q;
    assign ss_o    = ss_q;

    // R8: captured topology is frozen outside the stopped state
    p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |=> $stable(topo_q));

    // R9: losing the run condition always lands in the stopped state
    p_stop_to_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> (state_q == ST_OFF));

    // R10: clamp never passes a full period
    p_ss_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ss_q <= FULL);

endmodule

// File: rtl/pwm_drive_ctrl.sv
module pwm_drive_ctrl
    import pwm_drv_pkg::*;
#(
    parameter int CODE_W        = 8,
    parameter int RAMP_W        = 8,
    parameter int SS_STEP       = 16,
    parameter int DUTY_CEIL_PCT = 98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              ext_ok,
    input  logic              uv_flag,
    input  logic              ot_flag,
    input  logic              mode_sel,
    input  logic [CODE_W-1:0] err_code,
    input  logic [CODE_W-1:0] duty_cap,
    input  logic              cap_use,
    output logic              drv_hi,
    output logic              drv_lo
);

    localparam int PERIOD = 2 ** RAMP_W;
    localparam int WID_W  = RAMP_W + 1;
    localparam int FS     = (2 ** CODE_W) - 1;
    localparam int WIN_LO = win_code(FS, 1);
    localparam int WIN_HI = win_code(FS, 9);
    localparam int CEIL   = (PERIOD * DUTY_CEIL_PCT) / 100;

    logic              go;
    logic [RAMP_W-1:0] ramp;
    logic              wrap;
    drv_state_t        state;
    topo_t             topo;
    logic [WID_W-1:0]  ss_clamp;
    logic [WID_W-1:0]  width_d;
    logic [WID_W-1:0]  width_q;
    logic              active;

    assign go = run_en & ext_ok & ~uv_flag & ~ot_flag;

    pwm_ramp_cnt #(
        .RAMP_W (RAMP_W)
    ) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (ramp),
        .wrap_o (wrap)
    );

    pwm_seq_fsm #(
        .RAMP_W  (RAMP_W),
        .SS_STEP (SS_STEP)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .wrap_i  (wrap),
        .mode_i  (mode_sel),
        .state_o (state),
        .topo_o  (topo),
        .ss_o    (ss_clamp)
    );

    pwm_width_calc #(
        .CODE_W (CODE_W),
        .RAMP_W (RAMP_W),
        .WIN_LO (WIN_LO),
        .WIN_HI (WIN_HI),
        .CEIL   (CEIL)
    ) u_width (
        .comp_i    (err_code),
        .cap_i     (duty_cap),
        .cap_use_i (cap_use),
        .ss_i      (ss_clamp),
        .width_o   (width_d)
    );

    // width is taken only at the period boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
        end else if (wrap) begin
            width_q <= width_d;
        end
    end

    // output process: steer the pulse to the captured topology
    always_comb begin
        active = ((state == ST_SOFT) || (state == ST_RUN)) &&
                 ({1'b0, ramp} < width_q);
        drv_hi = active && (topo == TOPO_BUCK);
        drv_lo = active && (topo == TOPO_BOOST);
    end

    // R4: stored width never exceeds the hard ceiling
    p_width_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
        width_q <= WID_W'(CEIL));

    // R11: stored width only moves at a period boundary
    p_width_at_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(width_q));

    // R7: the idle side stays low for the captured topology
    p_idle_side_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (topo == TOPO_BUCK) |-> !drv_lo);

    // R9: any stop condition silences both outputs on the next edge
    p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (!drv_hi && !drv_lo));

endmodule

// File: tb/test_pwm_drive_ctrl.sv
module test_pwm_drive_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PER        = 256;
    localparam int SETTLE     = 2 * PER + 10;
    localparam int OPEN_WAIT  = 22 * PER;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       ext_ok = 1'b1;
    logic       uv_flag = 1'b0;
    logic       ot_flag = 1'b0;
    logic       mode_sel = 1'b1;
    logic [7:0] err_code = 8'd0;
    logic [7:0] duty_cap = 8'd0;
    logic       cap_use = 1'b0;
    logic       drv_hi;
    logic       drv_lo;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_drive_ctrl i_pwm_drive_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .ext_ok   (ext_ok),
        .uv_flag  (uv_flag),
        .ot_flag  (ot_flag),
        .mode_sel (mode_sel),
        .err_code (err_code),
        .duty_cap (duty_cap),
        .cap_use  (cap_use),
        .drv_hi   (drv_hi),
        .drv_lo   (drv_lo)
    );

    function automatic int exp_width(input int code, input int cap, input bit use_cap);
        int w;
        int lim;
        if (code < 26) w = 0;
        else if (code >= 230) w = 250;
        else w = ((code - 26) * 256) / 204;
        lim = (use_cap && cap < 250) ? cap : 250;
        if (lim < w) w = lim;
        if (w > 250) w = 250;
        return w;
    endfunction

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input int act, input int lo, input int hi, input string req);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0;
        lo = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            hi += int'(drv_hi);
            lo += int'(drv_lo);
        end
    endtask

    task automatic restart(input logic m);
        @(negedge clk);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        mode_sel = m;
        run_en = 1'b1;
        repeat (OPEN_WAIT) @(negedge clk);
    endtask

    task automatic set_and_check(input int code, input int cap, input bit use_cap,
                                 input bit buck, input string req);
        int hi;
        int lo;
        @(negedge clk);
        err_code = 8'(code);
        duty_cap = 8'(cap);
        cap_use  = use_cap;
        repeat (SETTLE) @(negedge clk);
        measure(hi, lo);
        check(buck ? hi : lo, exp_width(code, cap, use_cap), req);
        check(buck ? lo : hi, 0, {req, " idle side"});
    endtask

    task automatic t_reset();
        int hi;
        int lo;
        measure(hi, lo);
        check(hi + lo, 0, "R12 outputs low in reset");
        rst_n = 1'b1;
        measure(hi, lo);
        check(hi + lo, 0, "R12 outputs low after reset");
    endtask

    task automatic t_linear();
        restart(1'b1);
        set_and_check(128, 0, 1'b0, 1'b1, "R2 code 128");
        set_and_check(77, 0, 1'b0, 1'b1, "R2 code 77");
        set_and_check(179, 0, 1'b0, 1'b1, "R2 code 179");
    endtask

    task automatic t_dead_low();
        set_and_check(20, 0, 1'b0, 1'b1, "R1 code 20");
        set_and_check(25, 0, 1'b0, 1'b1, "R1 code 25");
        set_and_check(26, 0, 1'b0, 1'b1, "R1 code 26");
    endtask

    task automatic t_top();
        set_and_check(240, 0, 1'b0, 1'b1, "R3 code 240");
        set_and_check(255, 0, 1'b0, 1'b1, "R3 code 255");
        set_and_check(229, 0, 1'b0, 1'b1, "R4 code 229 ceiling");
    endtask

    task automatic t_cap();
        set_and_check(240, 64, 1'b1, 1'b1, "R5 cap 64");
        set_and_check(128, 100, 1'b1, 1'b1, "R5 cap 100");
        set_and_check(240, 0, 1'b1, 1'b1, "R5 cap 0");
        set_and_check(240, 255, 1'b1, 1'b1, "R6 cap above ceiling");
        set_and_check(240, 10, 1'b0, 1'b1, "R6 cap unused");
    endtask

    task automatic t_boost();
        @(negedge clk);
        err_code = 8'd128;
        cap_use = 1'b0;
        restart(1'b0);
        set_and_check(128, 0, 1'b0, 1'b0, "R7 boost low side");
    endtask

    task automatic t_mode_hold();
        int hi;
        int lo;
        @(negedge clk);
        mode_sel = 1'b1;
        repeat (SETTLE) @(negedge clk);
        measure(hi, lo);
        check(lo, 128, "R8 mode change ignored, low side");
        check(hi, 0, "R8 mode change ignored, high side");
        restart(1'b1);
        measure(hi, lo);
        check(hi, 128, "R8 new mode after restart");
        check(lo, 0, "R7 buck low side idle");
    endtask

    task automatic t_stop(input int kind, input string req);
        int hi;
        int lo;
        @(negedge clk);
        case (kind)
            0: run_en = 1'b0;
            1: ext_ok = 1'b0;
            2: uv_flag = 1'b1;
            default: ot_flag = 1'b1;
        endcase
        @(negedge clk);
        measure(hi, lo);
        check(hi + lo, 0, {"R9 stopped by ", req});
        run_en = 1'b1;
        ext_ok = 1'b1;
        uv_flag = 1'b0;
        ot_flag = 1'b0;
        measure(hi, lo);
        check(hi + lo, 0, {"R10 soft start rearmed after ", req});
        repeat (OPEN_WAIT) @(negedge clk);
        measure(hi, lo);
        check(hi, 128, {"R9 recovered after ", req});
    endtask

    task automatic t_soft();
        int hi;
        int lo;
        @(negedge clk);
        err_code = 8'd240;
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        run_en = 1'b1;
        measure(hi, lo);
        check(hi, 0, "R10 dark first window");
        repeat (2 * PER) @(negedge clk);
        measure(hi, lo);
        check_range(hi, 16, 48, "R10 partial clamp");
        repeat (OPEN_WAIT) @(negedge clk);
        measure(hi, lo);
        check(hi, 250, "R10 clamp fully open");
    endtask

    task automatic t_runt();
        int edges;
        logic prev;
        edges = 0;
        @(negedge clk);
        prev = drv_hi;
        for (int i = 0; i < 4 * PER; i++) begin
            @(negedge clk);
            err_code = (i % 2 == 0) ? 8'd100 : 8'd200;
            if (drv_hi && !prev) edges++;
            prev = drv_hi;
        end
        check(edges, 4, "R11 one pulse per period");
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        @(negedge clk);
        err_code = 8'd128;
        t_linear();
        t_dead_low();
        t_top();
        t_cap();
        t_boost();
        t_mode_hold();
        @(negedge clk);
        err_code = 8'd128;
        cap_use = 1'b0;
        t_stop(0, "enable low");
        t_stop(1, "external status");
        t_stop(2, "undervoltage");
        t_stop(3, "overtemperature");
        t_soft();
        t_runt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule